// File: doc/BRIEF.md
# Fall-Through Shift-Strobe FIFO

This block is a first-in first-out buffer of 64 words of 4 bits, built as a synchronous design. Words are written by strobing a shift-in level and taken out by strobing a shift-out level. Both strobes are sampled on the clock and act on their detected rising edge. There is no read or write address. A written word drops through the store to a single output stage on its own. An output-ready flag says when that stage holds a valid word. An input-ready flag says when the store has room for another word.

A word needs a fixed number of clock cycles to fall through to an empty output stage. The default is four cycles. The same wait applies to the next word after each removal. If the shift-out strobe is already high when a word arrives, that word is removed at once. Output-ready then shows a pulse one cycle wide. The strobe must return low before another word can be removed. A shift-in strobe that arrives while the buffer is full is dropped and changes nothing. An output enable floats the data outputs without touching the flags or the stored words. A synchronous clear empties the buffer.

Top module: `fallthru_fifo`

## Requirements
- R1: While `clr` is high at a clock edge, the buffer empties. After that edge `out_rdy` is 0 and `in_rdy` is 1. No word that was written before the clear ever reaches `q`.
- R2: A word is written only on a rising edge of `shift_in`, where the previous sample was 0 and the current sample is 1. Holding `shift_in` high for many cycles stores exactly one word.
- R3: Suppose a word is accepted at clock edge k and the output stage is empty. Then `out_rdy` rises after edge k+RIPPLE (default 4). After a removal at edge p, the next stored word appears after edge p+RIPPLE.
- R4: After the edge that accepts a word, `in_rdy` is 0 for one cycle. It then returns to 1 if fewer than DEPTH words are held. It stays 0 while DEPTH words are held.
- R5: A rising edge of `shift_out` while `out_rdy` is 1 removes the output word. `out_rdy` is 0 in the cycle after that.
- R6: A word may reach the output stage while `shift_out` is high and `shift_out` has been low at least once since the last removal. Then `out_rdy` is 1 for exactly one cycle, `q` shows that word during that cycle, and the word is removed.
- R7: After a removal, `shift_out` must be sampled low before another removal can happen. A word that arrives while `shift_out` stays high is kept, and `out_rdy` stays 1.
- R8: Words leave in the order they were written, with their data unchanged. DEPTH words (default 64) can be held, counting the output stage.
- R9: A `shift_in` rising edge that arrives while DEPTH words are held is ignored. The number of words and their contents do not change.
- R10: While `oe` is 0, `q` is high impedance. `out_rdy`, `in_rdy` and the stored words are unaffected. The output word is shown again once `oe` returns to 1.
- R11: `shift_in` rising edges are accepted regardless of `in_rdy`, at up to one every two cycles (one cycle high, one cycle low), as long as space remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high |
| shift_in | input | 1 | Write strobe level; a rising edge writes `din` |
| din | input | WIDTH | Data to write |
| shift_out | input | 1 | Removal strobe level |
| oe | input | 1 | Output enable; 0 floats `q` |
| in_rdy | output | 1 | Buffer has room for a word |
| out_rdy | output | 1 | Output stage holds a valid word |
| q | output | WIDTH | Output word, or high impedance |

## Verification
A wrong occupancy count shows up at the ports in one of two ways. Either `in_rdy` stays high past the 64th write, so overflow writes are accepted and later come out as extra words, or it drops early. A pointer or data-path fault shows as a wrong value or a wrong order on `q` within RIPPLE cycles of the removal that exposes the word. A faulty fall-through timer or arming flag shows as `out_rdy` rising a cycle early or late. It can also show as a missing one-cycle pulse, or as a second word removed while `shift_out` stays high. Each of these is visible within a few cycles of the strobe that causes it.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

    parameter int DEF_WIDTH  = 4;
    parameter int DEF_DEPTH  = 64;
    parameter int DEF_RIPPLE = 4;

    // next slot of a circular store of n entries
    function automatic int ring_next(input int p, input int n);
        return (p + 1 == n) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/ftf_rise.sv
module ftf_rise (
    input  logic clk,
    input  logic lvl,
    output logic rise
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl;
        rise  = lvl & ~lvl_q;
    end

    always_ff @(posedge clk) begin
        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/ftf_store.sv
module ftf_store
    import ftf_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_d, wp_q, rp_d, rp_q;

    always_comb begin
        wp_d = wp_q;
        rp_d = rp_q;
        if (wr_en) wp_d = AW'(ring_next(int'(wp_q), DEPTH));
        if (rd_en) rp_d = AW'(ring_next(int'(rp_q), DEPTH));
        if (clr) begin
            wp_d = '0;
            rp_d = '0;
        end
        rd_data = mem[rp_q];
    end

    always_ff @(posedge clk) begin
        wp_q <= wp_d;
        rp_q <= rp_d;
        if (wr_en) mem[wp_q] <= wr_data;
    end
endmodule

// File: rtl/ftf_ripple.sv
module ftf_ripple #(
    parameter int RIPPLE = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic arm,
    output logic due
);
    generate
        if (RIPPLE <= 1) begin : g_direct
            logic unused_in;
            assign unused_in = clk ^ clr;
            assign due = arm;
        end else begin : g_count
            localparam int TW = $clog2(RIPPLE);
            logic [TW-1:0] tmr_d, tmr_q;

            always_comb begin
                due = arm && (tmr_q == TW'(RIPPLE - 1));
                if (!arm || due || clr) tmr_d = '0;
                else                    tmr_d = tmr_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                tmr_q <= tmr_d;
            end
        end
    endgenerate
endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo
    import ftf_pkg::*;
#(
    parameter int WIDTH  = DEF_WIDTH,
    parameter int DEPTH  = DEF_DEPTH,
    parameter int RIPPLE = DEF_RIPPLE
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    input  logic             shift_out,
    input  logic             oe,
    output logic             in_rdy,
    output logic             out_rdy,
    output logic [WIDTH-1:0] q
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;    // words waiting behind the output stage
        logic             dor;    // output stage valid
        logic             dir;    // room flag
        logic             armed;  // shift_out seen low since last removal
        logic [WIDTH-1:0] data;   // output stage word
    } st_t;

    st_t st_d, st_q;

    logic             si_rise, acc, pop, load, waiting;
    logic [CW-1:0]    occ, occ_nx;
    logic [WIDTH-1:0] head;

    ftf_rise u_si_rise (
        .clk  (clk),
        .lvl  (shift_in),
        .rise (si_rise)
    );

    ftf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .clr     (clr),
        .wr_en   (acc),
        .wr_data (din),
        .rd_en   (load),
        .rd_data (head)
    );

    ftf_ripple #(.RIPPLE(RIPPLE)) u_ripple (
        .clk (clk),
        .clr (clr),
        .arm (waiting),
        .due (load)
    );

    always_comb begin
        occ     = st_q.cnt + CW'(st_q.dor);
        acc     = si_rise && !clr && (occ < CW'(DEPTH));
        pop     = st_q.dor && shift_out && st_q.armed;
        waiting = !st_q.dor && (st_q.cnt != '0) && !clr;

        st_d     = st_q;
        st_d.cnt = st_q.cnt + CW'(acc) - CW'(load);

        if (load) begin
            st_d.dor  = 1'b1;
            st_d.data = head;
        end else if (pop) begin
            st_d.dor = 1'b0;
        end

        if (pop)             st_d.armed = 1'b0;
        else if (!shift_out) st_d.armed = 1'b1;

        occ_nx   = st_d.cnt + CW'(st_d.dor);
        st_d.dir = (occ_nx < CW'(DEPTH)) && !acc;

        if (clr) begin
            st_d       = '0;
            st_d.dir   = 1'b1;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign in_rdy  = st_q.dir;
    assign out_rdy = st_q.dor;
    assign q       = oe ? st_q.data : 'z;
endmodule

// File: rtl/ftf_checker.sv
module ftf_checker #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          clr,
    input logic          shift_in,
    input logic          shift_out,
    input logic          in_rdy,
    input logic          out_rdy,
    input logic [CW-1:0] occ
);
    AST_CLEAR: assert property (@(posedge clk)
        clr |=> (!out_rdy && in_rdy)); // R1

    AST_DIR_DROP: assert property (@(posedge clk) disable iff (clr)
        (in_rdy && $rose(shift_in)) |=> !in_rdy); // R4

    AST_FULL_DIR: assert property (@(posedge clk) disable iff (clr)
        (occ == CW'(DEPTH)) |-> !in_rdy); // R4

    AST_SO_POP: assert property (@(posedge clk) disable iff (clr)
        (out_rdy && $rose(shift_out)) |=> !out_rdy); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (clr)
        occ <= CW'(DEPTH)); // R9
endmodule

bind fallthru_fifo ftf_checker #(.DEPTH(DEPTH), .CW(CW)) u_ftf_checker (
    .clk       (clk),
    .clr       (clr),
    .shift_in  (shift_in),
    .shift_out (shift_out),
    .in_rdy    (in_rdy),
    .out_rdy   (out_rdy),
    .occ       (occ)
);

// File: tb/test_fallthru_fifo.sv
`timescale 1ns/1ps
module test_fallthru_fifo;
    localparam int W   = 4;
    localparam int DEP = 64;
    localparam int RIP = 4;

    logic         clk = 1'b0;
    logic         clr, si, so, oe;
    logic [W-1:0] din;
    logic         in_rdy, out_rdy;
    logic [W-1:0] q;

    int checks = 0;
    int errs   = 0;

    fallthru_fifo #(.WIDTH(W), .DEPTH(DEP), .RIPPLE(RIP)) i_fallthru_fifo (
        .clk(clk), .clr(clr), .shift_in(si), .din(din), .shift_out(so),
        .oe(oe), .in_rdy(in_rdy), .out_rdy(out_rdy), .q(q)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int i);
        return W'((i * 5 + 3) % 16);
    endfunction

    // tasks start and end on a falling edge
    task automatic push(input logic [W-1:0] v);
        si = 1'b1; din = v;
        @(negedge clk);
        si = 1'b0;
    endtask

    task automatic pop();
        so = 1'b1;
        @(negedge clk);
        so = 1'b0;
    endtask

    task automatic wait_out(output int n);
        n = 0;
        while (!out_rdy && n < RIP + 8) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        int n, highs;
        logic [W-1:0] seen;
        clr = 1'b1; si = 1'b0; so = 1'b0; oe = 1'b1; din = '0;
        repeat (3) @(negedge clk);
        chk(out_rdy == 1'b0, "R1 out_rdy after clear", int'(out_rdy), 0);
        chk(in_rdy == 1'b1, "R1 in_rdy after clear", int'(in_rdy), 1);
        clr = 1'b0;
        @(negedge clk);

        // sweep every data value through an empty buffer
        for (int v = 0; v < 16; v++) begin
            push(W'(v));
            chk(in_rdy == 1'b0, "R4 in_rdy drops after accept", int'(in_rdy), 0);
            @(negedge clk);
            chk(in_rdy == 1'b1, "R4 in_rdy returns", int'(in_rdy), 1);
            wait_out(n);
            chk(n + 1 == RIP, "R3 fall-through latency", n + 1, RIP);
            chk(q == W'(v), "R8 data at output", int'(q), v);
            if (v == 10) begin
                oe = 1'b0;
                @(negedge clk);
                chk(q !== W'(v), "R10 q floats with oe low", int'(q), 0);
                chk(out_rdy == 1'b1, "R10 flag kept with oe low", int'(out_rdy), 1);
                oe = 1'b1;
                @(negedge clk);
                chk(q == W'(v), "R10 word back after oe", int'(q), v);
            end
            pop();
            chk(out_rdy == 1'b0, "R5 removal clears out_rdy", int'(out_rdy), 0);
            @(negedge clk);
        end

        // held shift_in stores one word
        si = 1'b1; din = 4'h9;
        repeat (10) @(negedge clk);
        si = 1'b0;
        wait_out(n);
        chk(q == 4'h9, "R2 held strobe word", int'(q), 9);
        pop();
        repeat (RIP + 4) @(negedge clk);
        chk(out_rdy == 1'b0, "R2 only one word stored", int'(out_rdy), 0);

        // automatic removal with shift_out held high
        so = 1'b1;
        @(negedge clk);
        push(4'h6);
        highs = 0; seen = '0;
        for (int j = 0; j < RIP + 6; j++) begin
            @(negedge clk);
            if (out_rdy) begin highs++; seen = q; end
        end
        chk(highs == 1, "R6 one-cycle output pulse", highs, 1);
        chk(seen == 4'h6, "R6 pulse word", int'(seen), 6);
        push(4'hB);
        repeat (RIP + 4) @(negedge clk);
        chk(out_rdy == 1'b1, "R7 word kept while so high", int'(out_rdy), 1);
        chk(q == 4'hB, "R7 kept word value", int'(q), 11);
        so = 1'b0;
        @(negedge clk);
        pop();
        chk(out_rdy == 1'b0, "R5 removal after rearm", int'(out_rdy), 0);
        @(negedge clk);

        // burst fill to capacity, then overflow attempts
        for (int i = 0; i < DEP; i++) begin
            push(pat(i));
            if (i == DEP - 1)
                chk(in_rdy == 1'b0, "R4 in_rdy low when full", int'(in_rdy), 0);
            @(negedge clk);
        end
        for (int i = 0; i < 4; i++) begin
            push(~pat(i));
            @(negedge clk);
        end
        chk(in_rdy == 1'b0, "R9 still full after overflow", int'(in_rdy), 0);
        for (int i = 0; i < DEP; i++) begin
            wait_out(n);
            if (i > 0) chk(n == RIP, "R3 refill latency", n, RIP);
            chk(out_rdy == 1'b1, "R11 burst word present", int'(out_rdy), 1);
            chk(q == pat(i), "R8 order and data", int'(q), int'(pat(i)));
            pop();
            if (i == 0) chk(in_rdy == 1'b1, "R4 room after removal", int'(in_rdy), 1);
        end
        wait_out(n);
        chk(out_rdy == 1'b0, "R9 overflow words dropped", int'(out_rdy), 0);

        // clear in the middle of traffic
        push(4'h1); @(negedge clk);
        push(4'h2); @(negedge clk);
        push(4'h3); @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(out_rdy == 1'b0, "R1 mid clear out_rdy", int'(out_rdy), 0);
        chk(in_rdy == 1'b1, "R1 mid clear in_rdy", int'(in_rdy), 1);
        repeat (RIP + 4) @(negedge clk);
        chk(out_rdy == 1'b0, "R1 cleared words gone", int'(out_rdy), 0);
        push(4'h7);
        @(negedge clk);
        wait_out(n);
        chk(n + 1 == RIP, "R3 latency after clear", n + 1, RIP);
        chk(q == 4'h7, "R1 first word after clear", int'(q), 7);
        pop();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule